// File: doc/BRIEF.md
# Decrement-and-Skip Execution Unit

This unit executes the two decrement-and-test instructions of an 8-bit microcontroller core. The first skips the next instruction when the decremented value is zero. The second skips it when the value is non-zero. Each instruction cycle is four clocks long, and the unit steps through them in a fixed order: decode, operand read, compute, write-back. It reads the addressed file register through a synchronous port, subtracts one with 8-bit wraparound, and writes the result either to the working register or back to the same file register. No status flag is touched.

When the skip test holds, the unit raises `squash` for whole instruction cycles. The fetch stage discards the word it has already fetched and runs a NOP in its place. If the fetch stage marks that word as the first half of a two-word instruction, the squash lasts two instruction cycles, so that both words are passed over. During squashed cycles the unit ignores new instructions and makes no register access.

The 12-bit file address comes from one of two sources, chosen per instruction. One is the 4-bit bank register concatenated with the 8-bit address field. The other is a fixed access bank, in which low addresses map to bank 0 and high addresses map to bank 15.

Top module: `decskip_unit`

## Requirements
- R1: While `rst_n` is low, `q_phase` is 0 and `rf_rd_en`, `rf_wr_en`, `w_wr_en` and `squash` are all low.
- R2: `q_phase` advances by one on every clock, 0→1→2→3→0, where 0 is decode, 1 is read, 2 is compute and 3 is write-back. After reset it starts at 0.
- R3: An instruction is taken only when `instr_valid` is high in phase 0 and bits [15:10] are 001011 (skip on zero) or 010011 (skip on non-zero). Any other word, or a low `instr_valid`, causes no read, no write and no squash.
- R4: A taken instruction asserts `rf_rd_en` in phase 1 of the same cycle. Bit 8 of the word selects the bank. When bit 8 is 1, `rf_addr` = {`bsr`, word[7:0]}. When bit 8 is 0, `rf_addr` = {4'h0, f} for f < 0x80 and {4'hF, f} for f ≥ 0x80, where f = word[7:0].
- R5: In phase 3 the result, read value minus one, is written. When bit 9 is 1, `rf_wr_en` is raised with `rf_wr_data` = result at the same `rf_addr`. When bit 9 is 0, `w_wr_en` is raised with `w_wr_data` = result. Exactly one of the two is raised.
- R6: For the skip-on-zero opcode, a result of 0x00 raises `squash` from the next phase 0. Any other result leaves `squash` low.
- R7: For the skip-on-non-zero opcode, a result other than 0x00 raises `squash` from the next phase 0. A result of 0x00 leaves `squash` low.
- R8: `squash` lasts 4 clocks (one instruction cycle) when `next_two_word` is low in the write-back phase, and 8 clocks when it is high.
- R9: While `squash` is high, `instr_valid` is ignored, and no read, file write or working-register write takes place.
- R10: The decrement wraps: a read value of 0x00 gives 0xFF, which counts as non-zero for the skip test.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one phase per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word present, sampled in phase 0 |
| instr_word | input | 16 | Instruction word |
| next_two_word | input | 1 | Prefetched word begins a two-word instruction, sampled in phase 3 |
| bsr | input | 4 | Bank-select register value |
| rf_rd_data | input | 8 | File read data, valid the clock after `rf_rd_en` |
| q_phase | output | 2 | Current phase within the instruction cycle |
| rf_rd_en | output | 1 | File read strobe |
| rf_addr | output | 12 | File address for read and write |
| rf_wr_en | output | 1 | File write strobe |
| rf_wr_data | output | 8 | File write data |
| w_wr_en | output | 1 | Working-register write strobe |
| w_wr_data | output | 8 | Working-register write data |
| squash | output | 1 | Discard the fetched word and run a NOP this cycle |

## Verification
A skip decision and the arrival of the next instruction meet in the same phase 0: the squash begins exactly where the fetch stage presents a new word. The bench provokes this by issuing a valid, file-writing instruction in the first squashed cycle, and in both cycles of a two-word squash. A behavioural model is compared with the outputs on every clock, and it must show no read or write for that cycle. The bench then reads back the file location that the ignored instruction targets, to confirm it was never decremented. Write-back and the two-word flag sample also share phase 3; this is checked by giving `next_two_word` both values on both skip senses and measuring the squash length.

// File: rtl/decskip_pkg.sv
// Shared widths, opcode codes, phase names and decoded-instruction record
// for the decrement-and-skip unit. Assumes an 8-bit data path.
package decskip_pkg;
    localparam int DATA_W  = 8;
    localparam int FA_W    = 8;
    localparam int BANK_W  = 4;
    localparam int RFA_W   = BANK_W + FA_W;
    localparam int OPC_W   = 6;
    localparam int WORD_W  = OPC_W + 2 + FA_W;
    localparam int NOP_W   = 2;

    localparam logic [OPC_W-1:0] OPC_DEC_SZ  = 6'b001011;
    localparam logic [OPC_W-1:0] OPC_DEC_SNZ = 6'b010011;

    localparam logic [BANK_W-1:0] ACC_LO_BANK = '0;
    localparam logic [BANK_W-1:0] ACC_HI_BANK = '1;

    typedef enum logic [1:0] {
        PH_DECODE = 2'd0,
        PH_READ   = 2'd1,
        PH_EXEC   = 2'd2,
        PH_WRITE  = 2'd3
    } phase_t;

    typedef struct packed {
        logic            skip_nz;
        logic            to_file;
        logic            use_bsr;
        logic [FA_W-1:0] faddr;
    } uop_t;
endpackage

// File: rtl/decskip_phase.sv
// Free-running four-phase sequencer. Assumes one phase per clock and that
// reset places the machine at the decode phase.
module decskip_phase
    import decskip_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase
);
    // Step the phase on every clock, wrapping after write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_DECODE;
        else        phase <= phase_t'(phase + 2'd1);
    end
endmodule

// File: rtl/decskip_decode.sv
// Combinational decoder for the two decrement-and-skip opcodes. Assumes
// the word layout opcode[15:10], dest[9], bank mode[8], address[7:0].
module decskip_decode
    import decskip_pkg::*;
(
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output logic              hit,
    output uop_t              uop
);
    logic [OPC_W-1:0] opc;

    // Split the word into its fields and flag a recognised opcode.
    always_comb begin
        opc          = word[WORD_W-1 -: OPC_W];
        uop.skip_nz  = (opc == OPC_DEC_SNZ);
        uop.to_file  = word[FA_W+1];
        uop.use_bsr  = word[FA_W];
        uop.faddr    = word[FA_W-1:0];
        hit          = valid && ((opc == OPC_DEC_SZ) || (opc == OPC_DEC_SNZ));
    end
endmodule

// File: rtl/decskip_bankmap.sv
// Forms the full file address from the bank mode, the bank register and
// the 8-bit field. Assumes the access bank splits at the field's top bit.
module decskip_bankmap
    import decskip_pkg::*;
(
    input  logic              use_bsr,
    input  logic [BANK_W-1:0] bsr,
    input  logic [FA_W-1:0]   faddr,
    output logic [RFA_W-1:0]  addr
);
    logic [BANK_W-1:0] bank;

    // Choose the bank from the register or from the fixed access split.
    always_comb begin
        if (use_bsr)            bank = bsr;
        else if (faddr[FA_W-1]) bank = ACC_HI_BANK;
        else                    bank = ACC_LO_BANK;
        addr = {bank, faddr};
    end
endmodule

// File: rtl/decskip_alu.sv
// Decrement with wraparound and skip test on the held result. Assumes the
// result is held stable in a register by the caller during write-back.
module decskip_alu
    import decskip_pkg::*;
(
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] held,
    input  logic              sense_nz,
    output logic [DATA_W-1:0] dec,
    output logic              skip
);
    logic held_zero;

    // Subtract one and evaluate the chosen skip sense.
    always_comb begin
        dec       = operand - DATA_W'(1);
        held_zero = (held == '0);
        skip      = sense_nz ? !held_zero : held_zero;
    end
endmodule

// File: rtl/decskip_unit.sv
// Decrement-and-skip execution unit: decodes in phase 0, reads in phase 1,
// decrements in phase 2, writes in phase 3, then squashes one or two
// instruction cycles when the skip holds. Assumes a file read returns data
// one clock after the strobe and bsr is stable across an instruction.
module decskip_unit
    import decskip_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    input  logic              next_two_word,
    input  logic [BANK_W-1:0] bsr,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic [1:0]        q_phase,
    output logic              rf_rd_en,
    output logic [RFA_W-1:0]  rf_addr,
    output logic              rf_wr_en,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              w_wr_en,
    output logic [DATA_W-1:0] w_wr_data,
    output logic              squash
);
    phase_t             phase;
    logic               hit;
    uop_t               uop_d;
    uop_t               uop_q;
    logic               active;
    logic [DATA_W-1:0]  res_q;
    logic [DATA_W-1:0]  dec;
    logic               skip;
    logic [NOP_W-1:0]   nop_cnt;

    decskip_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    decskip_decode u_dec (
        .valid (instr_valid),
        .word  (instr_word),
        .hit   (hit),
        .uop   (uop_d)
    );

    decskip_bankmap u_map (
        .use_bsr (uop_q.use_bsr),
        .bsr     (bsr),
        .faddr   (uop_q.faddr),
        .addr    (rf_addr)
    );

    decskip_alu u_alu (
        .operand  (rf_rd_data),
        .held     (res_q),
        .sense_nz (uop_q.skip_nz),
        .dec      (dec),
        .skip     (skip)
    );

    // Track the instruction in flight, its result and the squash count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            uop_q   <= '0;
            res_q   <= '0;
            nop_cnt <= '0;
        end else begin
            unique case (phase)
                PH_DECODE: begin
                    if (nop_cnt == '0) begin
                        active <= hit;
                        if (hit) uop_q <= uop_d;
                    end
                end
                PH_READ: begin
                end
                PH_EXEC: begin
                    if (active) res_q <= dec;
                end
                PH_WRITE: begin
                    if (active) begin
                        active <= 1'b0;
                        if (skip) nop_cnt <= next_two_word ? NOP_W'(2) : NOP_W'(1);
                    end else if (nop_cnt != '0) begin
                        nop_cnt <= nop_cnt - NOP_W'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Drive the strobes from the phase and the instruction in flight.
    always_comb begin
        q_phase    = phase;
        rf_rd_en   = active && (phase == PH_READ);
        rf_wr_en   = active && (phase == PH_WRITE) && uop_q.to_file;
        w_wr_en    = active && (phase == PH_WRITE) && !uop_q.to_file;
        rf_wr_data = res_q;
        w_wr_data  = res_q;
        squash     = (nop_cnt != '0);
    end
endmodule

// File: rtl/decskip_checker.sv
// Protocol checker for decskip_unit, attached by bind. Assumes it sees only
// the unit's ports; the squash run length is counted locally.
module decskip_checker
    import decskip_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        q_phase,
    input logic              rf_rd_en,
    input logic              rf_wr_en,
    input logic              w_wr_en,
    input logic              squash
);
    logic [3:0] sq_run;

    // Count consecutive clocks with squash high.
    always_ff @(posedge clk) begin
        if (!rst_n)      sq_run <= '0;
        else if (squash) sq_run <= sq_run + 4'd1;
        else             sq_run <= '0;
    end

    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q_phase == 2'($past(q_phase) + 2'd1)));

    a_r4_read_in_phase1: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en |-> (q_phase == 2'd1));

    a_r5_write_in_phase3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en || w_wr_en) |-> (q_phase == 2'd3));

    a_r5_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_wr_en && w_wr_en));

    a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en || w_wr_en) |-> $past(rf_rd_en, 2));

    a_r6_squash_starts_decode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(squash) |-> (q_phase == 2'd0));

    a_r8_squash_max_len: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> (sq_run < 4'd8));

    a_r9_quiet_in_squash: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> (!rf_rd_en && !rf_wr_en && !w_wr_en));
endmodule

bind decskip_unit decskip_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_phase  (q_phase),
    .rf_rd_en (rf_rd_en),
    .rf_wr_en (rf_wr_en),
    .w_wr_en  (w_wr_en),
    .squash   (squash)
);

// File: tb/decskip_unit_tb.sv
// Bench for decskip_unit: a behavioural model stepped on every clock is
// compared with the outputs at each falling edge, then the file contents
// and squash lengths are checked against hand-computed values.
module decskip_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [15:0] instr_word;
    logic        next_two_word;
    logic [3:0]  bsr;
    logic [7:0]  rf_rd_data;
    logic [1:0]  q_phase;
    logic        rf_rd_en;
    logic [11:0] rf_addr;
    logic        rf_wr_en;
    logic [7:0]  rf_wr_data;
    logic        w_wr_en;
    logic [7:0]  w_wr_data;
    logic        squash;

    int checks = 0;
    int errors = 0;
    bit run    = 1'b0;
    bit done   = 1'b0;
    int sq_clocks = 0;

    logic [7:0] mem [4096];
    logic [7:0] ref_mem [4096];
    logic [7:0] bw;

    int m_ph, m_nop;
    bit m_act, m_nz, m_d, m_a;
    logic [7:0] m_f, m_res;

    always #2 clk = ~clk;

    decskip_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .instr_word(instr_word), .next_two_word(next_two_word), .bsr(bsr),
        .rf_rd_data(rf_rd_data), .q_phase(q_phase), .rf_rd_en(rf_rd_en),
        .rf_addr(rf_addr), .rf_wr_en(rf_wr_en), .rf_wr_data(rf_wr_data),
        .w_wr_en(w_wr_en), .w_wr_data(w_wr_data), .squash(squash)
    );

    function automatic logic [11:0] map_addr(bit a, logic [3:0] b, logic [7:0] f);
        if (a) return {b, f};
        return {(f >= 8'h80) ? 4'hF : 4'h0, f};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Synchronous file and working register seen by the unit.
    always @(posedge clk) begin
        if (rf_rd_en) rf_rd_data <= mem[rf_addr];
        if (rf_wr_en) mem[rf_addr] <= rf_wr_data;
        if (w_wr_en)  bw <= w_wr_data;
        if (rst_n && squash) sq_clocks++;
    end

    // Behavioural reference, stepped on the same edges.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_nop = 0; m_act = 0;
        end else begin
            if (m_ph == 0) begin
                if (m_nop == 0 && instr_valid &&
                    (instr_word[15:10] == 6'b001011 || instr_word[15:10] == 6'b010011)) begin
                    m_act = 1; m_nz = instr_word[14]; m_d = instr_word[9];
                    m_a = instr_word[8]; m_f = instr_word[7:0];
                end else m_act = 0;
            end else if (m_ph == 1 && m_act) begin
                m_res = ref_mem[map_addr(m_a, bsr, m_f)] - 8'd1;
            end else if (m_ph == 3) begin
                if (m_act) begin
                    if (m_d) ref_mem[map_addr(m_a, bsr, m_f)] = m_res;
                    if (m_nz ? (m_res != 0) : (m_res == 0)) m_nop = next_two_word ? 2 : 1;
                    m_act = 0;
                end else if (m_nop > 0) m_nop--;
            end
            m_ph = (m_ph + 1) % 4;
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (run && rst_n) begin
            bit e_rd, e_wr, e_w;
            e_rd = m_act && m_ph == 1;
            e_wr = m_act && m_ph == 3 && m_d;
            e_w  = m_act && m_ph == 3 && !m_d;
            chk(q_phase == 2'(m_ph), "R2 phase", q_phase, m_ph);
            chk(rf_rd_en == e_rd, "R3 R4 R9 read strobe", rf_rd_en, e_rd);
            chk(rf_wr_en == e_wr, "R5 R9 file write strobe", rf_wr_en, e_wr);
            chk(w_wr_en == e_w, "R5 R9 W write strobe", w_wr_en, e_w);
            chk(squash == (m_nop > 0), "R6 R7 R8 squash", squash, m_nop > 0);
            if (e_rd || e_wr)
                chk(rf_addr == map_addr(m_a, bsr, m_f), "R4 address", rf_addr, map_addr(m_a, bsr, m_f));
            if (e_wr) chk(rf_wr_data == m_res, "R5 R10 file data", rf_wr_data, m_res);
            if (e_w)  chk(w_wr_data == m_res, "R5 R10 W data", w_wr_data, m_res);
        end
    end

    task automatic issue(input logic v, input logic [15:0] word, input logic two);
        while (q_phase != 2'd0) @(negedge clk);
        instr_valid = v; instr_word = word; next_two_word = two;
        @(negedge clk);
        instr_valid = 1'b0; instr_word = 16'h0000;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; instr_valid = 1'b0; instr_word = 16'h0;
        next_two_word = 1'b0; bsr = 4'h3; bw = 8'h00; rf_rd_data = 8'h00;
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i) ^ 8'h5A;
        mem[12'h310] = 8'h05; mem[12'h311] = 8'h01; mem[12'h312] = 8'h09;
        mem[12'h020] = 8'h03; mem[12'hF90] = 8'h01; mem[12'h313] = 8'h00;
        mem[12'h314] = 8'h00; mem[12'h07F] = 8'h01; mem[12'h315] = 8'h07;
        for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(q_phase == 2'd0, "R1 phase", q_phase, 0);
        chk({rf_rd_en, rf_wr_en, w_wr_en, squash} == 4'b0, "R1 strobes",
            {rf_rd_en, rf_wr_en, w_wr_en, squash}, 0);
        rst_n = 1'b1; run = 1'b1;
        issue(1, 16'h2F10, 0);   // R6: 5->4, no skip
        issue(1, 16'h2F11, 0);   // R6: 1->0, skip one cycle
        issue(1, 16'h2F12, 0);   // R9: lands in squash, ignored
        issue(1, 16'h4C20, 1);   // R7 R8: W=2, skip two cycles
        chk(bw == 8'h02, "R5 W result", bw, 2);
        issue(1, 16'h2F12, 0);   // R9: ignored
        issue(1, 16'h2F12, 0);   // R9: ignored
        issue(1, 16'h4E90, 1);   // R4 R7: bank 15, 1->0, no skip
        issue(1, 16'h2F13, 1);   // R10: 0->FF, zero-sense no skip
        issue(1, 16'h4F14, 0);   // R10 R7: 0->FF, skip one
        issue(0, 16'h0000, 0);
        issue(1, 16'h2C7F, 1);   // R4 R6 R8: bank 0, W=0, skip two
        issue(0, 16'h0000, 0);
        issue(0, 16'h0000, 0);
        issue(1, 16'h4B15, 0);   // R3: unknown opcode
        issue(0, 16'h2F15, 0);   // R3: valid low
        issue(0, 16'h0000, 0);
        chk(mem[12'h310] == 8'h04, "R5 decrement to file", mem[12'h310], 4);
        chk(mem[12'h311] == 8'h00, "R6 zero result", mem[12'h311], 0);
        chk(mem[12'h312] == 8'h09, "R9 squashed instr ignored", mem[12'h312], 9);
        chk(mem[12'h020] == 8'h03, "R5 W dest leaves file", mem[12'h020], 3);
        chk(mem[12'hF90] == 8'h00, "R4 access high bank", mem[12'hF90], 0);
        chk(mem[12'h313] == 8'hFF, "R10 wrap", mem[12'h313], 8'hFF);
        chk(mem[12'h314] == 8'hFF, "R10 wrap nz", mem[12'h314], 8'hFF);
        chk(mem[12'h07F] == 8'h01, "R4 access low bank W dest", mem[12'h07F], 1);
        chk(mem[12'h315] == 8'h07, "R3 no decode", mem[12'h315], 7);
        chk(bw == 8'h00, "R5 W last result", bw, 0);
        chk(sq_clocks == 24, "R8 total squash clocks", sq_clocks, 24);
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
        end
    end
endmodule